// File: doc/BRIEF.md
# Clock Request and Gating Tree

This block hands out one source clock to four peripheral clock outputs and decides, channel by channel, whether each output runs. Each channel has an asynchronous request pin whose active level is set in a configuration register. A per-channel override bit can replace the pin with a register enable bit. This lets a peripheral with no request line of its own still be served.

The effective channel requests are ORed into a request line for the upstream clock source and an enable for the supply regulator. Both are registered. Each output is gated without glitches. A channel's gate state is captured only on a falling edge of the source clock, so every pulse that leaves the block is a full half period. Each output can also be inverted. Configuration arrives through a simple parallel write port that stands in for a serial management bus.

Top module: `clk_req_tree`

## Requirements
- R1: While and after synchronous reset, every clock output is low and the source request and regulator enable are low. All polarity bits select active high, all override select bits are off, and all invert bits are off.
- R2: With reset settings, a request pin held high makes its channel output follow the source clock, and a pin held low keeps the output low.
- R3: When the polarity bit of a channel is 0, the pin requests the clock when it is low. When the bit is 1, the pin requests the clock when it is high.
- R4: When the override select bit of a channel is 1, the request pin is ignored and the override enable bit alone decides whether the channel is requested.
- R5: The source request and the regulator enable are equal. They are high exactly when at least one channel is effectively requested, one rising edge after the decoded request changes.
- R6: A channel's gate state changes only on a falling edge of the source clock. Starting and stopping therefore never produce a partial pulse.
- R7: When the invert bit of an enabled channel is 1, its output is the complement of the source clock. A disabled channel's output is low whatever its invert bit.
- R8: A write takes effect on a rising edge with wr_en high. wr_addr 0 selects polarity, 1 selects override select, 2 selects override enable and 3 selects invert, and data bit i belongs to channel i.
- R9: Channels are independent: a request on one channel does not start or stop any other channel's output.
- R10: Request pins pass through a two-stage synchronizer on rising source edges. A pin change is first visible at the outputs after the second rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Source clock; all logic runs on its edges |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 2 | Configuration register select |
| wr_data | input | 4 | Configuration write data, one bit per channel |
| req_pin | input | 4 | Asynchronous per-channel request pins |
| clk_out | output | 4 | Gated, optionally inverted channel clocks |
| src_req | output | 1 | Request for the source clock |
| reg_en | output | 1 | Regulator enable |

## Verification
A pin change applied just after a rising edge reaches the decoder after the second rising edge. The gate for the channel then follows at the next falling edge, half a cycle later, and src_req and reg_en follow at the third rising edge. A register write changes the decode at the edge it is written on, so the gates move half a cycle after that edge and the request outputs move one cycle after it. The tests drive inputs two time units after a rising edge. They read the outputs two units after a rising edge to see the high phase, or seven units after it to see the low phase. After a pin change they check that nothing has moved after two rising edges and that everything has moved after three. Checks in both clock phases tell inverted outputs from plain ones and show that gating starts only at the falling edge.

// File: rtl/clk_req_pkg.sv
package clk_req_pkg;
  typedef enum logic [1:0] {
    CFG_POL     = 2'd0,
    CFG_OVR_SEL = 2'd1,
    CFG_OVR_EN  = 2'd2,
    CFG_INV     = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/clk_req_cfg.sv
module clk_req_cfg
  import clk_req_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [1:0]     wr_addr,
  input  logic [NCH-1:0] wr_data,
  output logic [NCH-1:0] pol_hi,
  output logic [NCH-1:0] ovr_sel,
  output logic [NCH-1:0] ovr_en,
  output logic [NCH-1:0] inv_sel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pol_hi  <= '1;
      ovr_sel <= '0;
      ovr_en  <= '0;
      inv_sel <= '0;
    end else if (wr_en) begin
      case (cfg_sel_e'(wr_addr))
        CFG_POL:     pol_hi  <= wr_data;
        CFG_OVR_SEL: ovr_sel <= wr_data;
        CFG_OVR_EN:  ovr_en  <= wr_data;
        CFG_INV:     inv_sel <= wr_data;
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/clk_req_sync.sv
module clk_req_sync #(
  parameter int NCH    = 4,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] din,
  output logic [NCH-1:0] dout
);
  logic [NCH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= din;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[k] <= '0;
      else     chain[k] <= chain[k-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/clk_req_chan_gate.sv
module clk_req_chan_gate (
  input  logic sclk,
  input  logic rst,
  input  logic want,
  input  logic inv_cfg,
  output logic gate_o,
  output logic clk_o
);
  logic inv_q;

  // Gate and invert captured on the falling edge only: no partial pulses.
  always_ff @(negedge sclk) begin
    if (rst) begin
      gate_o <= 1'b0;
      inv_q  <= 1'b0;
    end else begin
      gate_o <= want;
      inv_q  <= inv_cfg;
    end
  end

  assign clk_o = gate_o & (sclk ^ inv_q);
endmodule

// File: rtl/clk_req_tree.sv
module clk_req_tree
  import clk_req_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic           sclk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [1:0]     wr_addr,
  input  logic [NCH-1:0] wr_data,
  input  logic [NCH-1:0] req_pin,
  output logic [NCH-1:0] clk_out,
  output logic           src_req,
  output logic           reg_en
);
  logic [NCH-1:0] pol_hi, ovr_sel, ovr_en, inv_sel;
  logic [NCH-1:0] pin_s, eff, gate;

  clk_req_cfg #(.NCH(NCH)) u_cfg (
    .clk(sclk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pol_hi(pol_hi), .ovr_sel(ovr_sel), .ovr_en(ovr_en), .inv_sel(inv_sel)
  );

  clk_req_sync #(.NCH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(sclk), .rst(rst), .din(req_pin), .dout(pin_s)
  );

  // Effective request: register override, else pin matched against polarity.
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      eff[i] = ovr_sel[i] ? ovr_en[i] : ~(pin_s[i] ^ pol_hi[i]);
    end
  end

  always_ff @(posedge sclk) begin
    if (rst) begin
      src_req <= 1'b0;
      reg_en  <= 1'b0;
    end else begin
      src_req <= |eff;
      reg_en  <= |eff;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    clk_req_chan_gate u_gate (
      .sclk(sclk), .rst(rst), .want(eff[c]), .inv_cfg(inv_sel[c]),
      .gate_o(gate[c]), .clk_o(clk_out[c])
    );
  end
endmodule

// File: rtl/clk_req_tree_chk.sv
module clk_req_tree_chk #(
  parameter int NCH = 4
) (
  input logic           sclk,
  input logic           rst,
  input logic [NCH-1:0] eff,
  input logic [NCH-1:0] gate,
  input logic           src_req,
  input logic           reg_en
);
  assert_req_pair_R5: assert property (@(posedge sclk) disable iff (rst)
    src_req == reg_en);

  assert_req_follow_R5: assert property (@(posedge sclk) disable iff (rst)
    src_req == $past(|eff));

  assert_gate_on_fall_R6: assert property (@(negedge sclk) disable iff (rst)
    gate == $past(eff));

  assert_reset_clear_R1: assert property (@(posedge sclk) disable iff (rst)
    $fell(rst) |-> (gate == '0 && !src_req && !reg_en));
endmodule

bind clk_req_tree clk_req_tree_chk #(.NCH(NCH)) u_chk (
  .sclk(sclk), .rst(rst), .eff(eff), .gate(gate),
  .src_req(src_req), .reg_en(reg_en)
);

// File: tb/clk_req_tree_tb.sv
module clk_req_tree_tb;
  localparam int CLK_PERIOD = 10;

  logic       sclk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [3:0] wr_data = 4'd0;
  logic [3:0] req_pin = 4'd0;
  logic [3:0] clk_out;
  logic       src_req, reg_en;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) sclk = ~sclk;

  clk_req_tree u_dut (
    .sclk(sclk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_pin(req_pin), .clk_out(clk_out), .src_req(src_req), .reg_en(reg_en)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge sclk);
    #2;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic clean();
    req_pin = 4'd0;
    wr(2'd0, 4'hF); wr(2'd1, 4'h0); wr(2'd2, 4'h0); wr(2'd3, 4'h0);
    tick(4);
  endtask

  // Pin change, then check the synchronizer latency (R10) and the outputs.
  task automatic pin_step(input logic [3:0] p, input logic [3:0] hi_exp,
                          input logic [3:0] lo_exp, input logic rq, input string req);
    logic [3:0] hi_old;
    logic       rq_old;
    hi_old = clk_out; rq_old = src_req;
    req_pin = p;
    tick(2);
    chk({4'd0, clk_out}, {4'd0, hi_old}, "R10 high phase unchanged after two edges");
    chk({7'd0, src_req}, {7'd0, rq_old}, "R10 src_req unchanged after two edges");
    tick(1);
    chk({4'd0, clk_out}, {4'd0, hi_exp}, {req, " high phase"});
    chk({6'd0, src_req, reg_en}, {6'd0, rq, rq}, {req, " R5 src_req/reg_en"});
    #5;
    chk({4'd0, clk_out}, {4'd0, lo_exp}, {req, " low phase"});
    tick(1);
  endtask

  task automatic t_reset();
    tick(1);
    chk({4'd0, clk_out}, 8'd0, "R1 outputs low in reset");
    chk({6'd0, src_req, reg_en}, 8'd0, "R1 requests low in reset");
    rst = 1'b0;
    tick(3);
    chk({4'd0, clk_out}, 8'd0, "R1 outputs low after reset");
    #5;
    chk({4'd0, clk_out}, 8'd0, "R1 outputs low after reset, low phase");
    tick(1);
    chk({6'd0, src_req, reg_en}, 8'd0, "R1 requests low after reset");
  endtask

  task automatic t_default_high();
    pin_step(4'b0001, 4'b0001, 4'b0000, 1'b1, "R2 pin high enables ch0");
    // Gate starts at the falling edge: check R6 mid-latency in the low phase.
    req_pin = 4'b0011;
    tick(2);
    #5;
    chk({4'd0, clk_out}, 8'd0, "R6 low phase right after enable edge");
    tick(1);
    chk({4'd0, clk_out}, 8'b0011, "R9 ch1 joins, ch0 unaffected");
    pin_step(4'b0000, 4'b0000, 4'b0000, 1'b0, "R2 pins low stop all");
  endtask

  task automatic t_stop_on_fall();
    clean();
    pin_step(4'b1000, 4'b1000, 4'b0000, 1'b1, "R6 ch3 start");
    req_pin = 4'b0000;
    tick(2);
    chk({4'd0, clk_out}, 8'b1000, "R6 full high pulse before stop");
    tick(1);
    chk({4'd0, clk_out}, 8'd0, "R6 stopped after falling edge");
    chk({7'd0, src_req}, 8'd0, "R5 request drops with last channel");
  endtask

  task automatic t_invert();
    clean();
    wr(2'd3, 4'b0110);
    tick(2);
    chk({4'd0, clk_out}, 8'd0, "R7 disabled inverted channels stay low");
    pin_step(4'b0010, 4'b0000, 4'b0010, 1'b1, "R7 ch1 inverted");
  endtask

  task automatic t_polarity();
    clean();
    wr(2'd0, 4'b1011);
    tick(2);
    chk({4'd0, clk_out}, 8'b0100, "R3 ch2 active low with pin low");
    chk({7'd0, src_req}, 8'd1, "R3 R5 request from active-low pin");
    pin_step(4'b0100, 4'b0000, 4'b0000, 1'b0, "R3 ch2 pin high releases");
  endtask

  task automatic t_override();
    clean();
    wr(2'd1, 4'b0001);
    tick(2);
    pin_step(4'b0001, 4'b0000, 4'b0000, 1'b0, "R4 pin ignored under override");
    wr(2'd2, 4'b0001);
    req_pin = 4'b0000;
    tick(2);
    chk({4'd0, clk_out}, 8'b0001, "R4 override enable runs ch0");
    chk({7'd0, reg_en}, 8'd1, "R4 R5 regulator from override");
    wr(2'd1, 4'b0000);
    tick(2);
    chk({4'd0, clk_out}, 8'd0, "R8 override select cleared, pin low");
    chk({7'd0, src_req}, 8'd0, "R8 request off after clear");
  endtask

  task automatic t_write_gate();
    clean();
    wr_en = 1'b0; wr_addr = 2'd0; wr_data = 4'b0000;
    tick(3);
    chk({4'd0, clk_out}, 8'd0, "R8 no write without wr_en");
    wr_en = 1'b0; wr_addr = 2'd0; wr_data = 4'b0000;
    req_pin = 4'b0000;
    tick(2);
    chk({7'd0, src_req}, 8'd0, "R8 polarity kept active high");
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++; checks++;
    $display("FAIL watchdog (R1..) actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(4);
    t_reset();
    t_default_high();
    t_stop_on_fall();
    t_invert();
    t_polarity();
    t_override();
    t_write_gate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule